// File: doc/BRIEF.md
# DRAM rank multiplication decoder

This block sits in a memory buffer between a host memory controller and a set of physical DRAM ranks. It lets two or four physical ranks stand behind one host chip select, so the host sees a single logical rank with more rows. When the host opens a row, the row address bits above the DRAM's native row width pick the physical rank. The block keeps that choice for each logical rank and bank. Later column and close commands to the same bank then go to the right physical rank without carrying any rank bits.

Commands that reach every bank (precharge of all banks, refresh, mode register writes) go to every physical rank behind the logical rank. The rank-select bits are cleared from the row address before it reaches the DRAM. Each command appears at the DRAM side exactly one clock after the host issues it.

Top module: `rank_mult_decoder`

## Requirements
- R1: Each host command appears on `dram_op`, `dram_bank` and `dram_row` exactly one clock later. Command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh and 6 mode register set. A command that reaches no physical rank is shown as no-op (0), with `phys_cs` all zero.
- R2: `mode` 2'b00 disables multiplication. Host chip select i drives physical chip select i, the row address passes through unchanged, and no table or error state is used.
- R3: In 2:1 mode (`mode` 2'b01) an activate on host chip select c selects physical rank 2*c + row bit 14. In 4:1 mode (`mode` 2'b10) it selects physical rank 4*c + row bits [15:14].
- R4: In 2:1 mode row bit 14 of `dram_row` is zero. In 4:1 mode bits [15:14] are zero. All other row bits pass through unchanged.
- R5: In a multiplication mode, a read or write is sent only to the physical rank that was stored by the last activate to the same host chip select and bank.
- R6: A precharge with row bit 10 low closes one bank. It goes to that bank's stored physical rank and clears the stored entry. If the bank has no stored entry, it goes to every physical rank behind the logical rank.
- R7: A precharge with row bit 10 high, and a refresh, go to all 2 (2:1) or 4 (4:1) physical ranks behind the logical rank. They also clear every stored entry of that logical rank.
- R8: A mode register set goes to all physical ranks behind the logical rank and leaves the stored entries unchanged.
- R9: A read or write to a bank with no stored entry drives no physical chip select. It sets `map_err`, which stays high until reset.
- R10: Host chip selects whose physical ranks would lie beyond the last physical chip select are ignored. In 4:1 mode these are host chip selects 2 and 3. They drive nothing and never set `map_err`.
- R11: Synchronous reset clears `phys_cs`, `dram_op`, `map_err` and every stored entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 3 | Decoded host command code |
| host_cs | input | 4 | Host chip selects, active high, at most one set |
| bank | input | 3 | Bank address |
| row_addr | input | 16 | Host row address, including rank-select bits |
| mode | input | 2 | Multiplication mode |
| phys_cs | output | 8 | Physical chip selects, active high |
| dram_op | output | 3 | Command code forwarded to the DRAM |
| dram_bank | output | 3 | Bank forwarded to the DRAM |
| dram_row | output | 16 | Row address with the rank-select bits cleared |
| map_err | output | 1 | Sticky error: column access to an unmapped bank |

## Verification
The assertions assume that the host drives at most one chip select at a time and holds `mode` steady between resets. Under those conditions, a column command always maps to exactly one rank, and the row-trim check can rely on the mode seen one cycle earlier.

The bench drives a single one-hot chip select per command. It changes mode only while reset is held, which also empties the bank table before each mode's scenario.

// File: rtl/rmd_pkg.sv
package rmd_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_MRS = 3'd6
  } op_e;

  localparam logic [1:0] MODE_DIS = 2'b00;
  localparam logic [1:0] MODE_X2  = 2'b01;
  localparam logic [1:0] MODE_X4  = 2'b10;
endpackage

// File: rtl/rmd_cs_map.sv
module rmd_cs_map #(
  parameter int N_HOST = 4,
  parameter int N_PHYS = 8,
  localparam int HIDX_W = $clog2(N_HOST)
) (
  input  logic              hit,
  input  logic [HIDX_W-1:0] host_idx,
  input  logic [1:0]        mode,
  input  logic [1:0]        sub,
  input  logic              bcast,
  output logic [N_PHYS-1:0] phys_mask
);
  import rmd_pkg::*;

  always_comb begin
    phys_mask = '0;
    if (hit) begin
      for (int k = 0; k < N_PHYS; k++) begin
        case (mode)
          MODE_X2: phys_mask[k] = ((k >> 1) == int'(host_idx)) &&
                                  (bcast || ((k & 1) == int'(sub[0])));
          MODE_X4: phys_mask[k] = ((k >> 2) == int'(host_idx)) &&
                                  (bcast || ((k & 3) == int'(sub)));
          default: phys_mask[k] = (k == int'(host_idx));
        endcase
      end
    end
  end
endmodule

// File: rtl/rmd_bank_table.sv
module rmd_bank_table #(
  parameter int N_LOG  = 4,
  parameter int N_BANK = 8,
  parameter int SUB_W  = 2,
  localparam int RANK_W = $clog2(N_LOG),
  localparam int BANK_W = $clog2(N_BANK),
  localparam int DEPTH  = 1 << (RANK_W + BANK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              clr_en,
  input  logic              clr_all_en,
  input  logic [RANK_W-1:0] rank,
  input  logic [BANK_W-1:0] bank,
  input  logic [SUB_W-1:0]  wr_sub,
  output logic              rd_valid,
  output logic [SUB_W-1:0]  rd_sub
);
  logic [RANK_W+BANK_W-1:0] addr;
  logic [SUB_W-1:0]         sub_mem [DEPTH];
  logic [DEPTH-1:0]         vld;

  assign addr = {rank, bank};

  // Sub-rank storage has no reset so it can map onto distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_en) sub_mem[addr] <= wr_sub;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[addr] <= 1'b1;
    end else if (clr_en) begin
      vld[addr] <= 1'b0;
    end else if (clr_all_en) begin
      for (int b = 0; b < N_BANK; b++) vld[{rank, BANK_W'(b)}] <= 1'b0;
    end
  end

  assign rd_valid = vld[addr];
  assign rd_sub   = sub_mem[addr];

  a_r6_bank_closed: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !wr_en) |=> !vld[$past(addr)]);

  a_r7_rank_emptied: assert property (@(posedge clk) disable iff (rst)
    (clr_all_en && !wr_en && !clr_en) |=> (vld[{$past(rank), BANK_W'(0)}] == 1'b0));
endmodule

// File: rtl/rank_mult_decoder.sv
module rank_mult_decoder #(
  parameter int N_HOST = 4,
  parameter int N_PHYS = 8,
  parameter int N_BANK = 8,
  parameter int ROW_W  = 14,
  localparam int HROW_W = ROW_W + 2,
  localparam int HIDX_W = $clog2(N_HOST),
  localparam int BANK_W = $clog2(N_BANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd_op,
  input  logic [N_HOST-1:0] host_cs,
  input  logic [BANK_W-1:0] bank,
  input  logic [HROW_W-1:0] row_addr,
  input  logic [1:0]        mode,
  output logic [N_PHYS-1:0] phys_cs,
  output logic [2:0]        dram_op,
  output logic [BANK_W-1:0] dram_bank,
  output logic [HROW_W-1:0] dram_row,
  output logic              map_err
);
  import rmd_pkg::*;

  op_e               op;
  logic              any_cs;
  logic [HIDX_W-1:0] host_idx;
  logic              mult;
  logic              in_range;
  logic [1:0]        act_sub;
  logic              tbl_valid;
  logic [1:0]        tbl_sub;
  logic              map_hit;
  logic              bcast;
  logic [1:0]        sel_sub;
  logic              tbl_wr;
  logic              tbl_clr;
  logic              tbl_clr_all;
  logic              err_set;
  logic [N_PHYS-1:0] mask;
  logic [HROW_W-1:0] row_trim;
  logic [1:0]        mode_q;

  assign op     = op_e'(cmd_op);
  assign any_cs = |host_cs;
  assign mult   = (mode == MODE_X2) || (mode == MODE_X4);

  always_comb begin
    host_idx = '0;
    for (int i = N_HOST - 1; i >= 0; i--) begin
      if (host_cs[i]) host_idx = HIDX_W'(i);
    end
  end

  always_comb begin
    case (mode)
      MODE_X2: in_range = (int'(host_idx) * 2) < N_PHYS;
      MODE_X4: in_range = (int'(host_idx) * 4) < N_PHYS;
      default: in_range = int'(host_idx) < N_PHYS;
    endcase
  end

  assign act_sub = (mode == MODE_X4) ? row_addr[ROW_W+1:ROW_W] : {1'b0, row_addr[ROW_W]};

  rmd_bank_table #(.N_LOG(N_HOST), .N_BANK(N_BANK), .SUB_W(2)) u_table (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (tbl_wr),
    .clr_en     (tbl_clr),
    .clr_all_en (tbl_clr_all),
    .rank       (host_idx),
    .bank       (bank),
    .wr_sub     (act_sub),
    .rd_valid   (tbl_valid),
    .rd_sub     (tbl_sub)
  );

  always_comb begin
    map_hit     = 1'b0;
    bcast       = 1'b0;
    sel_sub     = tbl_sub;
    tbl_wr      = 1'b0;
    tbl_clr     = 1'b0;
    tbl_clr_all = 1'b0;
    err_set     = 1'b0;
    if (any_cs && in_range && op != OP_NOP) begin
      if (!mult) begin
        map_hit = 1'b1;
      end else begin
        case (op)
          OP_ACT: begin
            map_hit = 1'b1;
            sel_sub = act_sub;
            tbl_wr  = 1'b1;
          end
          OP_RD, OP_WR: begin
            map_hit = tbl_valid;
            err_set = !tbl_valid;
          end
          OP_PRE: begin
            map_hit = 1'b1;
            if (row_addr[10]) begin
              bcast       = 1'b1;
              tbl_clr_all = 1'b1;
            end else if (tbl_valid) begin
              tbl_clr = 1'b1;
            end else begin
              bcast = 1'b1;
            end
          end
          OP_REF: begin
            map_hit     = 1'b1;
            bcast       = 1'b1;
            tbl_clr_all = 1'b1;
          end
          OP_MRS: begin
            map_hit = 1'b1;
            bcast   = 1'b1;
          end
          default: map_hit = 1'b0;
        endcase
      end
    end
  end

  rmd_cs_map #(.N_HOST(N_HOST), .N_PHYS(N_PHYS)) u_map (
    .hit       (map_hit),
    .host_idx  (host_idx),
    .mode      (mode),
    .sub       (sel_sub),
    .bcast     (bcast),
    .phys_mask (mask)
  );

  always_comb begin
    row_trim = row_addr;
    if (mode == MODE_X4) row_trim[ROW_W+1:ROW_W] = 2'b00;
    else if (mode == MODE_X2) row_trim[ROW_W] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_cs   <= '0;
      dram_op   <= OP_NOP;
      dram_bank <= '0;
      dram_row  <= '0;
      map_err   <= 1'b0;
      mode_q    <= MODE_DIS;
    end else begin
      phys_cs   <= mask;
      dram_op   <= (|mask) ? cmd_op : OP_NOP;
      dram_bank <= bank;
      dram_row  <= row_trim;
      mode_q    <= mode;
      if (err_set) map_err <= 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (dram_op == OP_NOP) |-> (phys_cs == '0));

  a_r5_single_rank: assert property (@(posedge clk) disable iff (rst)
    (dram_op == OP_RD || dram_op == OP_WR) |-> ($countones(phys_cs) == 1));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    map_err |=> map_err);

  a_r4_row_trim: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_X4) |-> (dram_row[HROW_W-1:ROW_W] == 2'b00));

  a_r7_refresh_fanout: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_X4 && dram_op == OP_REF) |-> ($countones(phys_cs) == 4));
endmodule

// File: tb/rank_mult_decoder_bench.sv
`timescale 1ns/1ps
module rank_mult_decoder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cmd_op;
  logic [3:0]  host_cs;
  logic [2:0]  bank;
  logic [15:0] row_addr;
  logic [1:0]  mode;
  logic [7:0]  phys_cs;
  logic [2:0]  dram_op;
  logic [2:0]  dram_bank;
  logic [15:0] dram_row;
  logic        map_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rank_mult_decoder u_rank_mult_decoder (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .host_cs(host_cs), .bank(bank),
    .row_addr(row_addr), .mode(mode), .phys_cs(phys_cs), .dram_op(dram_op),
    .dram_bank(dram_bank), .dram_row(dram_row), .map_err(map_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode = m; cmd_op = 3'd0; host_cs = 4'b0; bank = 3'd0; row_addr = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Drive on a falling edge, capture at the rising edge, check at the next falling edge.
  task automatic issue(input logic [2:0] op, input logic [3:0] cs,
                       input logic [2:0] bk, input logic [15:0] row);
    @(negedge clk);
    cmd_op = op; host_cs = cs; bank = bk; row_addr = row;
    @(negedge clk);
    cmd_op = 3'd0; host_cs = 4'b0;
  endtask

  task automatic t_reset;
    do_reset(2'b01);
    chk("R11 phys_cs", 32'(phys_cs), 32'h0);
    chk("R11 dram_op", 32'(dram_op), 32'h0);
    chk("R11 map_err", 32'(map_err), 32'h0);
    issue(3'd2, 4'b0001, 3'd0, 16'h0);
    chk("R11 table empty after reset", 32'(phys_cs), 32'h0);
  endtask

  task automatic t_passthru;
    do_reset(2'b00);
    issue(3'd1, 4'b0100, 3'd3, 16'hC123);
    chk("R2 act cs", 32'(phys_cs), 32'h04);
    chk("R2 row untouched", 32'(dram_row), 32'hC123);
    chk("R1 op", 32'(dram_op), 32'd1);
    chk("R1 bank", 32'(dram_bank), 32'd3);
    issue(3'd2, 4'b1000, 3'd6, 16'h0);
    chk("R2 read any cs", 32'(phys_cs), 32'h08);
    chk("R2 no error", 32'(map_err), 32'h0);
  endtask

  task automatic t_x2;
    do_reset(2'b01);
    issue(3'd1, 4'b0010, 3'd2, 16'h4ABC);
    chk("R3 x2 act rank", 32'(phys_cs), 32'h08);
    chk("R4 x2 row trim", 32'(dram_row), 32'h0ABC);
    issue(3'd1, 4'b1000, 3'd5, 16'h0011);
    chk("R3 x2 act rank6", 32'(phys_cs), 32'h40);
    issue(3'd2, 4'b0010, 3'd2, 16'h0000);
    chk("R5 x2 read steer", 32'(phys_cs), 32'h08);
    issue(3'd3, 4'b1000, 3'd5, 16'h0000);
    chk("R5 x2 write steer", 32'(phys_cs), 32'h40);
    chk("R5 write op", 32'(dram_op), 32'd3);
    issue(3'd4, 4'b0010, 3'd2, 16'h0000);
    chk("R6 precharge steer", 32'(phys_cs), 32'h08);
    issue(3'd2, 4'b0010, 3'd2, 16'h0000);
    chk("R6 entry cleared", 32'(phys_cs), 32'h0);
    chk("R1 dropped cmd is nop", 32'(dram_op), 32'd0);
    chk("R9 err set", 32'(map_err), 32'h1);
    repeat (4) @(negedge clk);
    chk("R9 err sticky", 32'(map_err), 32'h1);
    issue(3'd5, 4'b1000, 3'd0, 16'h0000);
    chk("R7 refresh x2 fanout", 32'(phys_cs), 32'hC0);
    issue(3'd2, 4'b1000, 3'd5, 16'h0000);
    chk("R7 refresh clears rank", 32'(phys_cs), 32'h0);
  endtask

  task automatic t_x4;
    do_reset(2'b10);
    issue(3'd1, 4'b0100, 3'd7, 16'h4000);
    chk("R10 cs2 act ignored", 32'(phys_cs), 32'h0);
    issue(3'd2, 4'b0100, 3'd7, 16'h0000);
    chk("R10 cs2 read ignored", 32'(phys_cs), 32'h0);
    chk("R10 no error", 32'(map_err), 32'h0);
    issue(3'd1, 4'b0010, 3'd7, 16'hC005);
    chk("R3 x4 act rank7", 32'(phys_cs), 32'h80);
    chk("R4 x4 row trim", 32'(dram_row), 32'h0005);
    issue(3'd1, 4'b0001, 3'd0, 16'h8000);
    chk("R3 x4 act rank2", 32'(phys_cs), 32'h04);
    issue(3'd2, 4'b0010, 3'd7, 16'h0000);
    chk("R5 x4 read", 32'(phys_cs), 32'h80);
    issue(3'd6, 4'b0001, 3'd0, 16'h0000);
    chk("R8 mrs fanout", 32'(phys_cs), 32'h0F);
    issue(3'd3, 4'b0001, 3'd0, 16'h0000);
    chk("R8 table kept after mrs", 32'(phys_cs), 32'h04);
    issue(3'd4, 4'b0001, 3'd3, 16'h0000);
    chk("R6 unmapped precharge fanout", 32'(phys_cs), 32'h0F);
    issue(3'd4, 4'b0010, 3'd0, 16'h0400);
    chk("R7 precharge-all fanout", 32'(phys_cs), 32'hF0);
    issue(3'd2, 4'b0010, 3'd7, 16'h0000);
    chk("R7 precharge-all clears", 32'(phys_cs), 32'h0);
    chk("R9 err after cleared read", 32'(map_err), 32'h1);
  endtask

  initial begin
    rst = 1'b1; mode = 2'b00; cmd_op = 3'd0; host_cs = 4'b0; bank = 3'd0; row_addr = 16'h0;
    t_reset();
    t_passthru();
    t_x2();
    t_x4();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule